// File: doc/BRIEF.md
# Multi-Subframe Pixel Readout Sequencer

This block produces the selection codes and marker timing for a pixel array that is cut into ten vertical subframes, each 64 columns wide. The subframes are grouped into two banks of five. Both banks run side by side, and each bank has its own serial output. For each readout step the sequencer gives the current row, the current column or marker slot, and the subframe picked in each bank for the current serial slot. The analog multiplexer downstream uses these codes. The block does not drive any analog signal itself.

Timing comes from two single-cycle enables on the system clock. The readout tick (nominally 10 MHz) advances the step. The serial slot tick moves through the five subframes of a bank within one step. A falling edge on the SYNC input resets the readout and starts it again after a latency of 6 or 7 ticks. The latency depends on the parity of a free-running tick counter. After that the frames repeat with no gap.

Status outputs mark four events:
- the internal reset;
- the start of the latency count;
- the first pixel, either once per frame or on every step;
- the last column of a row and the last row of a frame.

A test mode replaces pixel addresses with two alternating test levels.

Top module: `rdseq_top`

## Requirements
- R1: After reset, and before any SYNC fall, every output is 0.
- R2: A SYNC fall is seen when the registered SYNC is 1 and the input is 0. The first tick after the fall is tick 1. `rst_mk` is 1 for the tick period that tick 1 begins. `s_sync` is 1 for the tick period that tick 2 begins. Each is 0 at all other times.
- R3: Let c be the number of ticks seen since reset at the moment SYNC falls. The latency L is 7 when c is even and 6 when c is odd. `pix_on` goes to 1 at tick L+1, and that first step is marker Mk1 of the top row.
- R4: Each row has COLS+2 steps. Step 0 is Mk1 (`mark_slot`=1, `mark_hi`=1). Step 1 is Mk0 (`mark_slot`=1, `mark_hi`=0). Steps 2 to COLS+1 select columns COLS-1 down to 0 (`mark_slot`=0). `col` reads 0 during the two marker steps.
- R5: Rows are read from ROWS-1 down to 0. When `full_height`=1 they are read from 2*ROWS-1 down to 0. After row 0 the top row follows at once, and frames repeat until the next SYNC fall.
- R6: The slot index returns to 0 on every tick. Each slot tick advances it by one, and after SLOTS-1 it wraps to 0. While `pix_on`=1, `sf_b1` = 2*SLOTS-1-slot and `sf_b0` = SLOTS-1-slot. Both are 0 while `pix_on`=0.
- R7: With `test_mode`=0, `last_col` is 1 exactly during the final step of a row (column 0). With `test_mode`=0, `last_row` is 1 during every step of row 0.
- R8: With `mx_every`=0 and `test_mode`=0, `mx_first` is 1 for the whole of step 0 of the top row of each frame. With `mx_every`=1, `mx_first` is 1 during slot 0 of every step.
- R9: With `test_mode`=1:
  - `last_col` and `last_row` stay 0.
  - `mx_first` follows the per-step behaviour of R8 whatever the value of `mx_every`.
  - `tst_b1` is 1 when the slot parity equals the step parity, and `tst_b0` is its complement.

  With `test_mode`=0, both test-level outputs are 0.
- R10: A SYNC fall at any time, including mid-frame, drops `pix_on` and all address outputs to 0 by the next clock. Readout then restarts as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Readout tick enable, one cycle wide |
| slot_tick | input | 1 | Serial slot enable, one cycle wide |
| sync_in | input | 1 | Readout start token, acts on its falling edge |
| full_height | input | 1 | 1 selects twice as many rows |
| mx_every | input | 1 | 1 makes the first-pixel flag pulse on every step |
| test_mode | input | 1 | 1 selects test-level output |
| pix_on | output | 1 | Readout steps active |
| row | output | ROW_W | Current row |
| col | output | COL_W | Current column, 0 during markers |
| mark_slot | output | 1 | Current step is a marker |
| mark_hi | output | 1 | Marker is Mk1 (1) or Mk0 (0) |
| sf_b1 | output | SF_W | Subframe selected in bank 1 |
| sf_b0 | output | SF_W | Subframe selected in bank 0 |
| tst_b1 | output | 1 | Test level for bank 1 |
| tst_b0 | output | 1 | Test level for bank 0 |
| rst_mk | output | 1 | Readout-reset marker |
| s_sync | output | 1 | Start-of-latency marker |
| mx_first | output | 1 | First-pixel flag |
| last_col | output | 1 | Final column of a row |
| last_row | output | 1 | Final row of a frame |

## Verification
The assertions check these properties on every cycle:
- `rst_mk` and `s_sync` are never high together.
- `s_sync` rises only directly after `rst_mk`.
- `last_col` is only ever seen on column 0 of an active pixel step.
- Test mode keeps both end flags low.
- The bank-0 subframe code stays within range.
- Readout always begins on an Mk1 marker.

Only the bench scenarios can show the behaviours that count time or order:
- the parity-dependent 6-or-7 tick latency;
- the full step, row and frame order, including the wrap into a back-to-back frame;
- the two first-pixel behaviours;
- the alternation of the test levels;
- the abort and restart on a SYNC fall in the middle of a frame.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ARM, SQ_LAT, SQ_RUN} seq_st_t;
  localparam int LAT_W = 4;
endpackage

// File: rtl/rdseq_start.sv
module rdseq_start
  import rdseq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LAT_BASE = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sync_in,
  output logic fall,
  output logic start,
  output logic running,
  output logic rst_mk,
  output logic s_sync
);
  seq_st_t          st;
  logic             sync_q;
  logic [CNT_W-1:0] tcnt;
  logic             par_q;
  logic [LAT_W-1:0] lat_cnt;
  logic [LAT_W-1:0] lat_tgt;

  assign fall    = sync_q & ~sync_in;
  // an even counter value at the fall costs one extra tick
  assign lat_tgt = LAT_W'(LAT_BASE) + (par_q ? LAT_W'(0) : LAT_W'(1));
  assign start   = tick & ~fall & (st == SQ_LAT) & (lat_cnt == lat_tgt);
  assign running = (st == SQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      sync_q  <= 1'b0;
      tcnt    <= '0;
      par_q   <= 1'b0;
      lat_cnt <= '0;
      rst_mk  <= 1'b0;
      s_sync  <= 1'b0;
    end else begin
      sync_q <= sync_in;
      if (tick) tcnt <= tcnt + 1'b1;
      if (fall) begin
        st     <= SQ_ARM;
        par_q  <= tcnt[0];
        rst_mk <= 1'b0;
        s_sync <= 1'b0;
      end else if (tick) begin
        case (st)
          SQ_ARM: begin
            st      <= SQ_LAT;
            lat_cnt <= LAT_W'(1);
            rst_mk  <= 1'b1;
            s_sync  <= 1'b0;
          end
          SQ_LAT: begin
            rst_mk <= 1'b0;
            s_sync <= (lat_cnt == LAT_W'(1));
            if (lat_cnt == lat_tgt) st <= SQ_RUN;
            else                    lat_cnt <= lat_cnt + 1'b1;
          end
          default: begin
            rst_mk <= 1'b0;
            s_sync <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rdseq_scan.sv
module rdseq_scan #(
  parameter int ROWS   = 320,
  parameter int COLS   = 64,
  parameter int ROW_W  = 10,
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic              running,
  input  logic              full_height,
  output logic [STEP_W-1:0] step,
  output logic [ROW_W-1:0]  row,
  output logic              row_end,
  output logic              frame_first
);
  localparam int STEPS = COLS + 2;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

  logic [ROW_W-1:0] top_row;

  assign top_row     = full_height ? ROW_W'(2*ROWS - 1) : ROW_W'(ROWS - 1);
  assign row_end     = (step == STEP_LAST);
  assign frame_first = (step == '0) && (row == top_row);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      row  <= '0;
    end else if (start) begin
      step <= '0;
      row  <= top_row;
    end else if (tick && running) begin
      if (row_end) begin
        step <= '0;
        row  <= (row == '0) ? top_row : row - 1'b1;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdseq_slot.sv
module rdseq_slot #(
  parameter int SLOTS  = 5,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              slot_tick,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst || tick)  slot <= '0;
    else if (slot_tick)
      slot <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + 1'b1;
  end
endmodule

// File: rtl/rdseq_top.sv
module rdseq_top #(
  parameter int ROWS   = 320,
  parameter int COLS   = 64,
  parameter int SLOTS  = 5,
  parameter int CNT_W  = 8,
  parameter int ROW_W  = $clog2(2*ROWS),
  parameter int COL_W  = $clog2(COLS),
  parameter int SF_W   = $clog2(2*SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             slot_tick,
  input  logic             sync_in,
  input  logic             full_height,
  input  logic             mx_every,
  input  logic             test_mode,
  output logic             pix_on,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             mark_slot,
  output logic             mark_hi,
  output logic [SF_W-1:0]  sf_b1,
  output logic [SF_W-1:0]  sf_b0,
  output logic             tst_b1,
  output logic             tst_b0,
  output logic             rst_mk,
  output logic             s_sync,
  output logic             mx_first,
  output logic             last_col,
  output logic             last_row
);
  localparam int STEP_W = $clog2(COLS + 2);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [STEP_W-1:0] COL_OFS = STEP_W'(COLS + 1);

  logic              fall, start, running;
  logic [STEP_W-1:0] step;
  logic [ROW_W-1:0]  row_i;
  logic              row_end, frame_first;
  logic [SLOT_W-1:0] slot;
  logic [STEP_W-1:0] col_full;
  logic              is_mark;
  logic              par_eq;

  rdseq_start #(.CNT_W(CNT_W), .LAT_BASE(6)) u_start (
    .clk(clk), .rst(rst), .tick(tick), .sync_in(sync_in),
    .fall(fall), .start(start), .running(running),
    .rst_mk(rst_mk), .s_sync(s_sync)
  );

  rdseq_scan #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .STEP_W(STEP_W)) u_scan (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .running(running),
    .full_height(full_height), .step(step), .row(row_i),
    .row_end(row_end), .frame_first(frame_first)
  );

  rdseq_slot #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk(clk), .rst(rst), .tick(tick), .slot_tick(slot_tick), .slot(slot)
  );

  assign is_mark  = (step < STEP_W'(2));
  assign col_full = COL_OFS - step;
  assign par_eq   = ~(slot[0] ^ step[0]);

  always_comb begin
    pix_on    = running;
    row       = running ? row_i : '0;
    col       = (running && !is_mark) ? col_full[COL_W-1:0] : '0;
    mark_slot = running & is_mark;
    mark_hi   = running & (step == '0);
    sf_b1     = running ? SF_W'(2*SLOTS - 1) - SF_W'(slot) : '0;
    sf_b0     = running ? SF_W'(SLOTS - 1) - SF_W'(slot) : '0;
    tst_b1    = running & test_mode & par_eq;
    tst_b0    = running & test_mode & ~par_eq;
    mx_first  = running & ((mx_every | test_mode) ? (slot == '0) : frame_first);
    last_col  = running & ~test_mode & row_end;
    last_row  = running & ~test_mode & (row_i == '0);
  end
endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
  parameter int SLOTS = 5,
  parameter int COL_W = 6,
  parameter int SF_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             test_mode,
  input logic             pix_on,
  input logic             mark_slot,
  input logic             mark_hi,
  input logic [COL_W-1:0] col,
  input logic [SF_W-1:0]  sf_b0,
  input logic             rst_mk,
  input logic             s_sync,
  input logic             last_col,
  input logic             last_row
);
  // R2
  mk_excl_chk: assert property (@(posedge clk) disable iff (rst) !(rst_mk && s_sync));
  // R2
  ssync_order_chk: assert property (@(posedge clk) disable iff (rst) $rose(s_sync) |-> $past(rst_mk));
  // R7
  lastcol_pos_chk: assert property (@(posedge clk) disable iff (rst)
    last_col |-> (pix_on && !mark_slot && col == '0));
  // R9
  test_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> (!last_col && !last_row));
  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    pix_on |-> (sf_b0 <= SF_W'(SLOTS - 1)));
  // R3
  first_mk1_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_on) |-> (mark_slot && mark_hi));
endmodule

bind rdseq_top rdseq_chk #(.SLOTS(SLOTS), .COL_W(COL_W), .SF_W(SF_W)) u_chk (
  .clk(clk), .rst(rst), .test_mode(test_mode), .pix_on(pix_on),
  .mark_slot(mark_slot), .mark_hi(mark_hi), .col(col), .sf_b0(sf_b0),
  .rst_mk(rst_mk), .s_sync(s_sync), .last_col(last_col), .last_row(last_row)
);

// File: tb/tb_rdseq_top.sv
`timescale 1ns/1ps
module tb_rdseq_top;
  localparam int ROWS  = 3;
  localparam int COLS  = 4;
  localparam int SLOTS = 5;
  localparam int ROW_W = $clog2(2*ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int SF_W  = $clog2(2*SLOTS);
  localparam int STEPS = COLS + 2;
  localparam int VW    = 1 + ROW_W + COL_W + 2 + 2*SF_W + 7;
  localparam int NSC   = 5;
  // scenario table: ticks before the fall, full_height, mx_every, test_mode, ticks checked
  localparam int T_PRE  [NSC] = '{3, 4, 5, 2, 3};
  localparam int T_FULL [NSC] = '{0, 0, 1, 0, 0};
  localparam int T_MX   [NSC] = '{0, 1, 0, 0, 0};
  localparam int T_TEST [NSC] = '{0, 0, 0, 1, 0};
  localparam int T_LEN  [NSC] = '{45, 30, 50, 25, 30};

  logic clk = 0;
  logic rst, tick, slot_tick, sync_in, full_height, mx_every, test_mode;
  logic             pix_on, mark_slot, mark_hi, tst_b1, tst_b0;
  logic             rst_mk, s_sync, mx_first, last_col, last_row;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [SF_W-1:0]  sf_b1, sf_b0;

  int n_run = 0, n_fail = 0;
  int ph = 0, ntick = 0;

  always #2.5 clk = ~clk;

  rdseq_top #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) dut (
    .clk(clk), .rst(rst), .tick(tick), .slot_tick(slot_tick), .sync_in(sync_in),
    .full_height(full_height), .mx_every(mx_every), .test_mode(test_mode),
    .pix_on(pix_on), .row(row), .col(col), .mark_slot(mark_slot), .mark_hi(mark_hi),
    .sf_b1(sf_b1), .sf_b0(sf_b0), .tst_b1(tst_b1), .tst_b0(tst_b0),
    .rst_mk(rst_mk), .s_sync(s_sync), .mx_first(mx_first),
    .last_col(last_col), .last_row(last_row)
  );

  function automatic logic [VW-1:0] got_vec();
    return {pix_on, row, col, mark_slot, mark_hi, sf_b1, sf_b0, tst_b1, tst_b0,
            rst_mk, s_sync, mx_first, last_col, last_row};
  endfunction

  // expected outputs k ticks after the SYNC fall, in serial slot s
  function automatic logic [VW-1:0] exp_vec(int k, int lat, int s, int fh, int mx, int tm);
    logic run, mk, mkh, t1, t0, mxf, lc, lr;
    int p, stp, ri, rr, nrow, cc;
    logic [ROW_W-1:0] rv;
    logic [COL_W-1:0] cv;
    logic [SF_W-1:0]  s1, s0;
    nrow = fh ? 2*ROWS : ROWS;
    run = (k >= lat + 1);
    p   = run ? k - lat - 1 : 0;
    stp = p % STEPS;
    ri  = (p / STEPS) % nrow;
    rr  = nrow - 1 - ri;
    cc  = (stp >= 2) ? COLS + 1 - stp : 0;
    rv  = run ? ROW_W'(rr) : '0;
    cv  = run ? COL_W'(cc) : '0;
    mk  = run && stp < 2;
    mkh = run && stp == 0;
    s1  = run ? SF_W'(2*SLOTS - 1 - s) : '0;
    s0  = run ? SF_W'(SLOTS - 1 - s) : '0;
    t1  = run && tm != 0 && ((s % 2) == (stp % 2));
    t0  = run && tm != 0 && ((s % 2) != (stp % 2));
    mxf = run && ((mx != 0 || tm != 0) ? (s == 0) : (stp == 0 && ri == 0));
    lc  = run && tm == 0 && stp == STEPS - 1;
    lr  = run && tm == 0 && rr == 0;
    return {run, rv, cv, mk, mkh, s1, s0, t1, t0, (k == 1), (k == 2), mxf, lc, lr};
  endfunction

  task automatic check(string tag, logic [VW-1:0] exp);
    n_run++;
    if (got_vec() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got_vec(), exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
    ph = (ph == 9) ? 0 : ph + 1;
    tick      = (ph == 0);
    slot_tick = (ph == 2 || ph == 4 || ph == 6 || ph == 8);
    if (tick && !rst) ntick++;
  endtask

  task automatic to_phase(int p);
    do adv(); while (ph != p);
  endtask

  task automatic run_scn(int pre, int fh, int mx, int tm, int len);
    int c, lat;
    full_height = fh[0];
    mx_every    = mx[0];
    test_mode   = tm[0];
    sync_in     = 1'b1;
    repeat (pre + 1) to_phase(5);
    sync_in = 1'b0;
    c   = ntick;
    lat = (c % 2 == 0) ? 7 : 6;
    to_phase(7);
    check("R10 outputs cleared after SYNC fall", exp_vec(0, lat, 0, fh, mx, tm));
    for (int k = 1; k <= len; k++) begin
      to_phase(1);
      check("R2 R3 R4 R5 R7 R8 R9 slot0", exp_vec(k, lat, 0, fh, mx, tm));
      to_phase(3);
      check("R6 R9 slot1", exp_vec(k, lat, 1, fh, mx, tm));
      to_phase(9);
      check("R6 R8 slot4", exp_vec(k, lat, 4, fh, mx, tm));
    end
  endtask

  initial begin
    rst = 1; tick = 0; slot_tick = 0; sync_in = 0;
    full_height = 0; mx_every = 0; test_mode = 0;
    repeat (25) adv();
    check("R1 state in reset", '0);
    rst = 0;
    repeat (30) adv();
    to_phase(1);
    check("R1 idle after reset", '0);
    for (int i = 0; i < NSC; i++)
      run_scn(T_PRE[i], T_FULL[i], T_MX[i], T_TEST[i], T_LEN[i]);
    // R10: the last scenario started while the previous frame was still running
    // R3: opposite parity start, one extra tick before the fall
    run_scn(0, 0, 1, 1, 12);
    run_scn(1, 0, 0, 0, 12);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule